// File: doc/BRIEF.md
# Credit-Debit Trigger Aggregator

The block turns event pulses from several distributed sources into one global, level-sensitive enable. Each source raises a credit to open a region of interest and a debit to close it. The block keeps two running totals in a base clock domain and holds the enable high while the credit total exceeds the debit total. Because the enable depends on the balance of the two totals, several sources can open overlapping regions, and the enable falls only once every credit has been matched by a debit.

Every source signal passes through one register stage into the base domain before it is counted. The enable is then re-registered in the clock of each sink before it leaves the block. A source port can behave as a plain pulse source, as a level source (the rising edge credits, the falling edge debits) or as a start/stop source (the rising edge of one input credits, the rising edge of the other debits). Events raised while a port's local reset is high are dropped, unless that port is configured to count them anyway. A sticky error flag reports an excess of debits. When the block is built with no sources, every sink is tied to a build-time default.

Top module: `trig_aggregator`

## Requirements
- R1: While rst_ni is low, every sink output and err_o are 0; after a reset both totals start again from zero.
- R2: Every source input passes through one base-clock register before it is counted, so a credit pulse on a pulse-mode port appears on a sink clocked by clk_i exactly 2 clk_i cycles after the cycle in which it was driven, and a matching debit removes it with the same latency.
- R3: In each cycle the credit total grows by the number of ports that carry a credit event and the debit total by the number of ports that carry a debit event; the enable is high exactly when the unsigned credit total is greater than the debit total.
- R4: A credit and a debit on the same port in the same cycle are both counted, so the balance and the enable do not change and err_o stays low.
- R5: An event is dropped while its port's local reset src_rst_i[i] is high, unless bit i of CNT_IN_RST is 1, in which case it is counted.
- R6: Port i's mode is the 2-bit field SRC_MODES[2i+1:2i]: 0 = pulse (src_a_i credits, src_b_i debits each cycle they are high), 1 = level (rising edge of src_a_i credits, falling edge debits), 2 = start/stop (rising edge of src_a_i credits, rising edge of src_b_i debits, falling edges ignored).
- R7: err_o goes high, in the same cycle the enable would update, as soon as the debit total exceeds the credit total, and it stays high until rst_ni is low.
- R8: Every sink output is a register clocked by its own snk_clk_i bit, and once the sources are quiet all sinks show the same enable.
- R9: With N_SRC = 0 every sink output is the constant NO_SRC_DEFAULT (1 unless overridden) and err_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock for capture and counting |
| rst_ni | input | 1 | Asynchronous active-low reset for the whole block |
| src_a_i | input | SRC_W | Per-port credit / level / start input |
| src_b_i | input | SRC_W | Per-port debit / stop input |
| src_rst_i | input | SRC_W | Per-port local reset, active high, masks that port's events |
| snk_clk_i | input | N_SNK | Clock of each sink |
| snk_trig_o | output | N_SNK | Enable delivered to each sink |
| err_o | output | 1 | Sticky flag: debits have exceeded credits |

## Verification
The two functions that can fall in one cycle are crediting and debiting: a single port can carry both, and different ports can carry opposite events in the same cycle. Directed cases drive a credit and a debit on one port together, both while the enable is low and while it is high, and require the enable and the error flag to stay where they were two cycles later. The random phase drives credits, debits, level toggles and local resets on all ports at once, and each cycle it compares the base-domain sink and the error flag with a bench model that sums the same events.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic [1:0] {
    SRC_PULSE = 2'd0,
    SRC_LEVEL = 2'd1,
    SRC_EDGE  = 2'd2
  } src_mode_e;
endpackage

// File: rtl/trig_src_port.sv
module trig_src_port #(
  parameter trig_pkg::src_mode_e MODE       = trig_pkg::SRC_PULSE,
  parameter bit                  CNT_IN_RST = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  input  logic b_i,
  input  logic lrst_i,
  output logic credit_o,
  output logic debit_o
);
  logic a_q, a_qq, b_q, b_qq, lr_q;
  logic cr, db, keep;

  // single capture stage into base domain, second stage only for edge detect
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q  <= 1'b0;
      a_qq <= 1'b0;
      b_q  <= 1'b0;
      b_qq <= 1'b0;
      lr_q <= 1'b0;
    end else begin
      a_q  <= a_i;
      a_qq <= a_q;
      b_q  <= b_i;
      b_qq <= b_q;
      lr_q <= lrst_i;
    end
  end

  always_comb begin
    unique case (MODE)
      trig_pkg::SRC_LEVEL: begin
        cr = a_q & ~a_qq;
        db = ~a_q & a_qq;
      end
      trig_pkg::SRC_EDGE: begin
        cr = a_q & ~a_qq;
        db = b_q & ~b_qq;
      end
      default: begin
        cr = a_q;
        db = b_q;
      end
    endcase
  end

  assign keep     = CNT_IN_RST | ~lr_q;
  assign credit_o = cr & keep;
  assign debit_o  = db & keep;
endmodule

// File: rtl/trig_accum.sv
module trig_accum #(
  parameter int N       = 4,
  parameter int COUNT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N-1:0]       c_evt_i,
  input  logic [N-1:0]       d_evt_i,
  output logic [COUNT_W-1:0] cred_o,
  output logic [COUNT_W-1:0] deb_o,
  output logic               trig_nx_o,
  output logic               err_o
);
  logic [COUNT_W-1:0] cred_q, deb_q, cred_nx, deb_nx;
  logic               err_q;

  function automatic logic [COUNT_W-1:0] popc(input logic [N-1:0] v);
    logic [COUNT_W-1:0] s;
    s = '0;
    for (int i = 0; i < N; i++) s = s + COUNT_W'(v[i]);
    return s;
  endfunction

  assign cred_nx = cred_q + popc(c_evt_i);
  assign deb_nx  = deb_q + popc(d_evt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cred_q <= '0;
      deb_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      cred_q <= cred_nx;
      deb_q  <= deb_nx;
      err_q  <= err_q | (deb_nx > cred_nx);
    end
  end

  // compare next totals so the sink stage sees them without an extra cycle
  assign trig_nx_o = cred_nx > deb_nx;
  assign cred_o    = cred_q;
  assign deb_o     = deb_q;
  assign err_o     = err_q;
endmodule

// File: rtl/trig_sink_reg.sv
module trig_sink_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/trig_aggregator.sv
module trig_aggregator #(
  parameter int N_SRC   = 4,
  parameter int N_SNK   = 2,
  parameter int COUNT_W = 16,
  localparam int SRC_W  = (N_SRC > 0) ? N_SRC : 1,
  parameter logic [2*SRC_W-1:0] SRC_MODES  = '0,
  parameter logic [SRC_W-1:0]   CNT_IN_RST = '0,
  parameter bit                 NO_SRC_DEFAULT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_W-1:0] src_a_i,
  input  logic [SRC_W-1:0] src_b_i,
  input  logic [SRC_W-1:0] src_rst_i,
  input  logic [N_SNK-1:0] snk_clk_i,
  output logic [N_SNK-1:0] snk_trig_o,
  output logic             err_o
);
  logic [SRC_W-1:0]   c_evt, d_evt;
  logic [COUNT_W-1:0] cred_cnt, deb_cnt;
  logic               trig_nx;

  if (N_SRC > 0) begin : g_src
    for (genvar i = 0; i < N_SRC; i++) begin : g_port
      trig_src_port #(
        .MODE       (trig_pkg::src_mode_e'(SRC_MODES[2*i +: 2])),
        .CNT_IN_RST (CNT_IN_RST[i])
      ) u_port (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .a_i      (src_a_i[i]),
        .b_i      (src_b_i[i]),
        .lrst_i   (src_rst_i[i]),
        .credit_o (c_evt[i]),
        .debit_o  (d_evt[i])
      );
    end

    trig_accum #(.N(N_SRC), .COUNT_W(COUNT_W)) u_accum (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .c_evt_i   (c_evt),
      .d_evt_i   (d_evt),
      .cred_o    (cred_cnt),
      .deb_o     (deb_cnt),
      .trig_nx_o (trig_nx),
      .err_o     (err_o)
    );

    for (genvar s = 0; s < N_SNK; s++) begin : g_snk
      trig_sink_reg u_snk (
        .clk_i  (snk_clk_i[s]),
        .rst_ni (rst_ni),
        .d_i    (trig_nx),
        .q_o    (snk_trig_o[s])
      );
    end
  end else begin : g_nosrc
    assign c_evt      = '0;
    assign d_evt      = '0;
    assign cred_cnt   = '0;
    assign deb_cnt    = '0;
    assign trig_nx    = 1'b0;
    assign err_o      = 1'b0;
    assign snk_trig_o = {N_SNK{NO_SRC_DEFAULT}};
  end
endmodule

module trig_aggregator_chk #(
  parameter int SRC_W   = 4,
  parameter int COUNT_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [SRC_W-1:0]   c_evt,
  input logic [SRC_W-1:0]   d_evt,
  input logic [COUNT_W-1:0] cred_cnt,
  input logic [COUNT_W-1:0] deb_cnt,
  input logic               trig_nx,
  input logic               err_o
);
  // R3
  cred_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    COUNT_W'(cred_cnt - $past(cred_cnt)) <= COUNT_W'(SRC_W));

  // R3
  deb_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    COUNT_W'(deb_cnt - $past(deb_cnt)) <= COUNT_W'(SRC_W));

  // R4
  bal_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(c_evt) == $countones(d_evt)) |=>
      (COUNT_W'(cred_cnt - deb_cnt) == COUNT_W'($past(cred_cnt) - $past(deb_cnt))));

  // R3
  bal_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cred_cnt == deb_cnt) && (c_evt == '0)) |-> !trig_nx);

  // R7
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

bind trig_aggregator trig_aggregator_chk #(.SRC_W(SRC_W), .COUNT_W(COUNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .c_evt    (c_evt),
  .d_evt    (d_evt),
  .cred_cnt (cred_cnt),
  .deb_cnt  (deb_cnt),
  .trig_nx  (trig_nx),
  .err_o    (err_o)
);

// File: tb/test_trig_aggregator.sv
`timescale 1ns/1ps
module test_trig_aggregator;
  logic       clk = 1'b0, sclk = 1'b0, rst_n = 1'b0;
  logic [2:0] a = '0, b = '0, lr = '0;
  logic [1:0] snk;
  logic       err;
  logic [1:0] ns_def, ns_zero;
  logic       ns_err0, ns_err1;
  int         n_tests = 0, n_fail = 0;
  bit         done = 1'b0, chk_en = 1'b0;

  always #4 clk  = ~clk;
  always #6 sclk = ~sclk;

  // port0 pulse, port1 level, port2 start/stop (counts under local reset)
  trig_aggregator #(
    .N_SRC(3), .N_SNK(2), .COUNT_W(12),
    .SRC_MODES(6'b10_01_00), .CNT_IN_RST(3'b100)
  ) i_trig_aggregator (
    .clk_i(clk), .rst_ni(rst_n), .src_a_i(a), .src_b_i(b), .src_rst_i(lr),
    .snk_clk_i({sclk, clk}), .snk_trig_o(snk), .err_o(err)
  );

  trig_aggregator #(.N_SRC(0), .N_SNK(2)) i_trig_aggregator_def (
    .clk_i(clk), .rst_ni(rst_n), .src_a_i(1'b0), .src_b_i(1'b0), .src_rst_i(1'b0),
    .snk_clk_i({sclk, clk}), .snk_trig_o(ns_def), .err_o(ns_err0)
  );

  trig_aggregator #(.N_SRC(0), .N_SNK(2), .NO_SRC_DEFAULT(1'b0)) i_trig_aggregator_zero (
    .clk_i(clk), .rst_ni(rst_n), .src_a_i(1'b0), .src_b_i(1'b0), .src_rst_i(1'b0),
    .snk_clk_i({sclk, clk}), .snk_trig_o(ns_zero), .err_o(ns_err1)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // events per port: bit0 credit, bit1 debit
  function automatic logic [1:0] evt_of(input int mode, input logic aq, aqq, bq, bqq);
    case (mode)
      1:       return {~aq & aqq, aq & ~aqq};
      2:       return {bq & ~bqq, aq & ~aqq};
      default: return {bq, aq};
    endcase
  endfunction

  int         m_cred, m_deb;
  logic       m_trig, m_err;
  logic [2:0] m_aq, m_aqq, m_bq, m_bqq, m_rq;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cred = 0; m_deb = 0; m_trig = 0; m_err = 0;
      m_aq = '0; m_aqq = '0; m_bq = '0; m_bqq = '0; m_rq = '0;
    end else begin
      for (int i = 0; i < 3; i++) begin
        logic [1:0] e;
        e = evt_of(i, m_aq[i], m_aqq[i], m_bq[i], m_bqq[i]);
        if (i == 2 || !m_rq[i]) begin
          m_cred += int'(e[0]);
          m_deb  += int'(e[1]);
        end
      end
      m_trig = m_cred > m_deb;
      m_err  = m_err | (m_deb > m_cred);
      m_aqq = m_aq; m_aq = a; m_bqq = m_bq; m_bq = b; m_rq = lr;
    end
  end

  always @(negedge clk) if (chk_en && !done) begin
    chk(snk[0], m_trig, "R3 model");
    chk(err, m_err, "R7 model");
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    chk_en = 1'b0;
    rst_n = 1'b0; a = '0; b = '0; lr = '0;
    cyc(2);
    chk(snk[0], 1'b0, "R1"); chk(snk[1], 1'b0, "R1"); chk(err, 1'b0, "R1");
    rst_n = 1'b1;
    chk_en = 1'b1;
    cyc(2);
  endtask

  initial begin
    void'($urandom(32'd7741));
    cyc(1);
    do_reset();
    chk(ns_def[0], 1'b1, "R9"); chk(ns_def[1], 1'b1, "R9");
    chk(ns_zero[0], 1'b0, "R9"); chk(ns_zero[1], 1'b0, "R9"); chk(ns_err0, 1'b0, "R9");

    // R2 credit latency
    a[0] = 1; cyc(1); chk(snk[0], 1'b0, "R2"); a[0] = 0; cyc(1); chk(snk[0], 1'b1, "R2");
    // R4 credit and debit together while enabled
    a[0] = 1; b[0] = 1; cyc(1); a[0] = 0; b[0] = 0; cyc(3);
    chk(snk[0], 1'b1, "R4"); chk(err, 1'b0, "R4");
    // R2 debit latency
    b[0] = 1; cyc(1); chk(snk[0], 1'b1, "R2"); b[0] = 0; cyc(1); chk(snk[0], 1'b0, "R2");
    // R4 together while balanced
    a[0] = 1; b[0] = 1; cyc(1); a[0] = 0; b[0] = 0; cyc(3);
    chk(snk[0], 1'b0, "R4"); chk(err, 1'b0, "R4");
    // R5 masked credit
    lr[0] = 1; a[0] = 1; cyc(1); a[0] = 0; lr[0] = 0; cyc(3);
    chk(snk[0], 1'b0, "R5");
    // R5 port counting under local reset, R6 start/stop mode
    lr[2] = 1; a[2] = 1; cyc(3); chk(snk[0], 1'b1, "R5");
    b[2] = 1; cyc(3); chk(snk[0], 1'b0, "R5");
    lr[2] = 0; a[2] = 0; b[2] = 0; cyc(3); chk(snk[0], 1'b0, "R6"); chk(err, 1'b0, "R6");
    // R6 level mode, R8 foreign sink
    a[1] = 1; cyc(3); chk(snk[0], 1'b1, "R6"); cyc(5); chk(snk[0], 1'b1, "R6");
    chk(snk[1], 1'b1, "R8");
    a[1] = 0; cyc(3); chk(snk[0], 1'b0, "R6"); cyc(4); chk(snk[1], 1'b0, "R8");
    // R7 excess debit, sticky
    b[0] = 1; cyc(1); b[0] = 0; cyc(2); chk(err, 1'b1, "R7"); chk(snk[0], 1'b0, "R7");
    a[0] = 1; cyc(1); a[0] = 0; cyc(3); chk(err, 1'b1, "R7"); chk(snk[0], 1'b0, "R3");
    a[0] = 1; cyc(1); a[0] = 0; cyc(3); chk(snk[0], 1'b1, "R3");
    // R1 reset clears totals and flag
    do_reset();
    chk(err, 1'b0, "R1");
    a[0] = 1; cyc(1); a[0] = 0; cyc(2); chk(snk[0], 1'b1, "R1");
    do_reset();

    // random phase
    for (int k = 0; k < 3000; k++) begin
      a[0] = ($urandom % 5) == 0;
      b[0] = ($urandom % 6) == 0;
      if (($urandom % 9) == 0) a[1] = ~a[1];
      if (($urandom % 4) == 0) a[2] = ~a[2];
      if (($urandom % 5) == 0) b[2] = ~b[2];
      for (int j = 0; j < 3; j++) lr[j] = ($urandom % 10) == 0;
      cyc(1);
      if ((k % 200) == 199) begin
        a[0] = 0; b[0] = 0; lr = '0;
        cyc(8);
        chk(snk[1], snk[0], "R8");
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule